// File: doc/BRIEF.md
# Configuration Word Stream Parser

This block sits at the front of a configuration loader. It takes 16-bit configuration words one at a time through a valid/ready handshake. It ignores everything until it sees a 32-bit synchronisation pattern arrive as two consecutive accepted words. After that lock, it reads packet headers. It sends the payload words of register writes out on a simple write bus and keeps a running CRC over everything it wrote. Payload words aimed at the CRC register are not forwarded: they are compared against the running CRC.

The image ends when the producer marks a word as last. After that word the block accepts nothing more until reset. It then reports exactly one of three results. `done` means a clean CRC check closed the image. `crc_error` means a compare failed. `incomplete_error` means the stream stopped before any CRC check, after unchecked writes, or in the middle of a packet. A truncated image therefore never reports `done`.

The handshake follows these rules. `in_ready` is high from reset until the last word has been accepted, and low from the next cycle on. A word is consumed only in a cycle where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low change nothing. The producer may hold `in_valid` high across any number of cycles and may insert gaps of any length.

Top module: `cfg_stream_parser`

## Requirements
- R1: `sync_found` rises one cycle after the block accepts the word 0x5566, if the word accepted just before it was 0xAA99. Gaps with `in_valid` low do not break the pair. Any other accepted word in between does. Before the lock, no word is decoded and no write strobe occurs.
- R2: A header with bits [15:13] = 001 is decoded as follows: [12:11] is the opcode, [10:5] the register address and [4:0] the word count. With opcode 10 (write), a non-zero count and a non-zero address, each of the next count words gives one `wr_strobe` pulse, with `wr_addr` set to the header address and `wr_data` set to the word. These outputs appear one cycle after the word is accepted.
- R3: A 001 header whose opcode is not 10, or whose count is zero, consumes no payload. The next accepted word is treated as a header.
- R4: Payload words sent to address 0 produce no strobe. They are taken in pairs, first the upper half and then the lower half of a 32-bit value. On the second word of a pair the value is compared with the running CRC. On a mismatch `crc_error` rises one cycle later and stays high. An unpaired trailing word is dropped. Header 0x3002 therefore carries exactly one check.
- R5: The running CRC starts at zero at sync. For each strobed write it processes the 22 bits {address, data}, most significant bit first. It uses a left-shifting 32-bit CRC with polynomial 0x04C11DB7 and no final inversion. A matching compare resets it to zero.
- R6: A header with bits [15:13] = 010 takes a word count from bits [10:0]. The payload goes to the address of the most recent 001 header. If that address is 0, the words are treated as CRC words as in R4.
- R7: A header whose bits [15:13] are neither 001 nor 010 sets the sticky `fmt_error` one cycle later. It is otherwise ignored, and the next word is a header.
- R8: One cycle after the block accepts a word with `in_last` high, `in_ready` drops and stays low. At that point either `done` or `incomplete_error` may rise. `done` rises if all of these hold: `crc_error` is low, sync was found, no packet is open, and a matching compare came after the last strobed write. Otherwise, if `crc_error` is low, `incomplete_error` rises. A word offered while `in_ready` is low has no effect.
- R9: `done` is never high while `crc_error` is high, or while `incomplete_error` is high.
- R10: A word is consumed only when `in_valid` and `in_ready` are both high. Idle cycles alter neither the decoding position nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 16 | Configuration word |
| in_last | input | 1 | Marks the final word of the image |
| sync_found | output | 1 | Synchronisation pattern seen |
| wr_strobe | output | 1 | Register write pulse |
| wr_addr | output | 6 | Register address for the write |
| wr_data | output | 16 | Register data for the write |
| crc_error | output | 1 | Sticky CRC compare mismatch |
| fmt_error | output | 1 | Sticky unknown header type |
| incomplete_error | output | 1 | Stream ended without a clean closing check |
| done | output | 1 | Stream ended with a clean closing check |

## Verification
The most delicate coincidence is the lower CRC word arriving as the last word of the stream. In that one accepted word, the compare result, the CRC clear and the end-of-stream verdict all have to be settled together. The `done` decision must use the compare outcome of that same word, not the stale clean flag. The stimulus table ends a valid image this way and expects `done` one cycle after the word. A directed test ends a stream on a mismatching lower word and expects `crc_error` with neither `done` nor `incomplete_error`. A second coincidence is also covered: a payload word that is also the last word must strobe and flag the stream incomplete in the same cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int CNT1_W   = 5;
  localparam int CNT2_W   = 11;
  localparam int CRC_W    = 2 * WORD_W;
  localparam int CRC_IN_W = ADDR_W + WORD_W;

  localparam logic [2:0]        KIND_T1  = 3'b001;
  localparam logic [2:0]        KIND_T2  = 3'b010;
  localparam logic [1:0]        OP_WRITE = 2'b10;
  localparam logic [ADDR_W-1:0] CRC_ADDR = '0;

  typedef enum logic [2:0] {
    ST_HUNT, ST_HDR, ST_DATA, ST_CHK, ST_END
  } pst_t;

  function automatic logic [CRC_W-1:0] crc_fold(
    input logic [CRC_W-1:0]    seed,
    input logic [CRC_IN_W-1:0] bits,
    input logic [CRC_W-1:0]    poly
  );
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = seed;
    for (int i = CRC_IN_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ bits[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ poly;
    end
    return acc;
  endfunction
endpackage

// File: rtl/cfgp_sync_hunt.sv
module cfgp_sync_hunt
  import cfgp_pkg::*;
#(
  parameter logic [CRC_W-1:0] SYNC_PATTERN = 32'hAA995566
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic              locked
);
  localparam logic [WORD_W-1:0] PAT_HI = SYNC_PATTERN[CRC_W-1:WORD_W];
  localparam logic [WORD_W-1:0] PAT_LO = SYNC_PATTERN[WORD_W-1:0];

  logic [WORD_W-1:0] prev_word;
  logic              prev_ok;

  assign hit = take && !locked && prev_ok &&
               (prev_word == PAT_HI) && (word == PAT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_word <= '0;
      prev_ok   <= 1'b0;
      locked    <= 1'b0;
    end else begin
      if (take && !locked) begin
        prev_word <= word;
        prev_ok   <= 1'b1;
      end
      if (hit) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgp_crc_accum.sv
module cfgp_crc_accum
  import cfgp_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_next;

  always_comb begin
    crc_next = crc;
    if (clr)      crc_next = '0;
    else if (upd) crc_next = crc_fold(crc, {addr, data}, CRC_POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= '0;
    else        crc <= crc_next;
  end
endmodule

// File: rtl/cfgp_pkt_fsm.sv
module cfgp_pkt_fsm
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  input  logic              last,
  input  logic              hit,
  input  logic [CRC_W-1:0]  crc_now,
  output logic              accepting,
  output logic              crc_upd,
  output logic              crc_clr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              crc_error,
  output logic              fmt_error,
  output logic              incomplete_error,
  output logic              done
);
  pst_t              st, st_go, st_n;
  logic [CNT2_W-1:0] rem, rem_n;
  logic [ADDR_W-1:0] addr_n;
  logic [WORD_W-1:0] hi_q, hi_n;
  logic              half_q, half_n;
  logic              clean_q, clean_n;
  logic              fire, chk_ok, chk_bad, fmt_hit;
  logic              tail_ok, crc_err_n;

  wire [2:0]        h_kind = word[15:13];
  wire [1:0]        h_op   = word[12:11];
  wire [ADDR_W-1:0] h_addr = word[10:5];
  wire [CNT1_W-1:0] h_cnt1 = word[CNT1_W-1:0];
  wire [CNT2_W-1:0] h_cnt2 = word[CNT2_W-1:0];

  assign accepting = (st != ST_END);

  always_comb begin
    st_go   = st;
    rem_n   = rem;
    addr_n  = cur_addr;
    hi_n    = hi_q;
    half_n  = half_q;
    clean_n = clean_q;
    fire    = 1'b0;
    chk_ok  = 1'b0;
    chk_bad = 1'b0;
    fmt_hit = 1'b0;
    if (take) begin
      unique case (st)
        ST_HUNT: if (hit) st_go = ST_HDR;
        ST_HDR: begin
          if (h_kind == KIND_T1) begin
            addr_n = h_addr;
            if (h_op == OP_WRITE && h_cnt1 != '0) begin
              rem_n  = {{(CNT2_W-CNT1_W){1'b0}}, h_cnt1};
              half_n = 1'b0;
              st_go  = (h_addr == CRC_ADDR) ? ST_CHK : ST_DATA;
            end
          end else if (h_kind == KIND_T2) begin
            if (h_cnt2 != '0) begin
              rem_n  = h_cnt2;
              half_n = 1'b0;
              st_go  = (cur_addr == CRC_ADDR) ? ST_CHK : ST_DATA;
            end
          end else begin
            fmt_hit = 1'b1;
          end
        end
        ST_DATA: begin
          fire    = 1'b1;
          clean_n = 1'b0;
          rem_n   = rem - 1'b1;
          if (rem == CNT2_W'(1)) st_go = ST_HDR;
        end
        ST_CHK: begin
          if (!half_q) begin
            hi_n   = word;
            half_n = 1'b1;
          end else begin
            half_n = 1'b0;
            if ({hi_q, word} == crc_now) begin
              chk_ok  = 1'b1;
              clean_n = 1'b1;
            end else begin
              chk_bad = 1'b1;
              clean_n = 1'b0;
            end
          end
          rem_n = rem - 1'b1;
          if (rem == CNT2_W'(1)) st_go = ST_HDR;
        end
        default: st_go = st;
      endcase
    end
    st_n      = (take && last) ? ST_END : st_go;
    tail_ok   = (st_go == ST_HDR) && clean_n;
    crc_err_n = crc_error || chk_bad;
  end

  assign crc_upd = fire;
  assign crc_clr = chk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st               <= ST_HUNT;
      rem              <= '0;
      cur_addr         <= '0;
      hi_q             <= '0;
      half_q           <= 1'b0;
      clean_q          <= 1'b0;
      wr_strobe        <= 1'b0;
      wr_addr          <= '0;
      wr_data          <= '0;
      crc_error        <= 1'b0;
      fmt_error        <= 1'b0;
      incomplete_error <= 1'b0;
      done             <= 1'b0;
    end else begin
      st        <= st_n;
      rem       <= rem_n;
      cur_addr  <= addr_n;
      hi_q      <= hi_n;
      half_q    <= half_n;
      clean_q   <= clean_n;
      wr_strobe <= fire;
      if (fire) begin
        wr_addr <= cur_addr;
        wr_data <= word;
      end
      crc_error <= crc_err_n;
      if (fmt_hit) fmt_error <= 1'b1;
      if (take && last && !crc_err_n) begin
        if (tail_ok) done             <= 1'b1;
        else         incomplete_error <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfgp_pkg::*;
#(
  parameter logic [CRC_W-1:0] SYNC_PATTERN = 32'hAA995566,
  parameter logic [CRC_W-1:0] CRC_POLY     = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_last,
  output logic              sync_found,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              crc_error,
  output logic              fmt_error,
  output logic              incomplete_error,
  output logic              done
);
  logic              take, hit, locked;
  logic              crc_upd, crc_clr;
  logic [ADDR_W-1:0] cur_addr;
  logic [CRC_W-1:0]  crc_now;

  assign take       = in_valid && in_ready;
  assign sync_found = locked;

  cfgp_sync_hunt #(.SYNC_PATTERN(SYNC_PATTERN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .word   (in_word),
    .hit    (hit),
    .locked (locked)
  );

  cfgp_crc_accum #(.CRC_POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (crc_upd),
    .clr   (crc_clr),
    .addr  (cur_addr),
    .data  (in_word),
    .crc   (crc_now)
  );

  cfgp_pkt_fsm u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .take             (take),
    .word             (in_word),
    .last             (in_last),
    .hit              (hit),
    .crc_now          (crc_now),
    .accepting        (in_ready),
    .crc_upd          (crc_upd),
    .crc_clr          (crc_clr),
    .cur_addr         (cur_addr),
    .wr_strobe        (wr_strobe),
    .wr_addr          (wr_addr),
    .wr_data          (wr_data),
    .crc_error        (crc_error),
    .fmt_error        (fmt_error),
    .incomplete_error (incomplete_error),
    .done             (done)
  );
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
  import cfgp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              sync_found,
  input logic              wr_strobe,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              crc_error,
  input logic              fmt_error,
  input logic              incomplete_error,
  input logic              done
);
  a_r1_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |=> sync_found);

  a_r1_strobe_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> sync_found);

  a_r10_strobe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(in_valid && in_ready));

  a_r4_no_strobe_crc_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_addr != CRC_ADDR));

  a_r4_crc_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |=> crc_error);

  a_r7_fmt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_error |=> fmt_error);

  a_r8_ready_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || incomplete_error) |-> !in_ready);

  a_r8_no_strobe_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || incomplete_error) |=> !wr_strobe);

  a_r9_done_excludes_errors: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(crc_error || incomplete_error));
endmodule

bind cfg_stream_parser cfgp_checker u_chk (.*);

// File: tb/tb_cfg_stream_parser.sv
`timescale 1ns/1ps
module tb_cfg_stream_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        in_last = 1'b0;
  logic        sync_found, wr_strobe, crc_error, fmt_error, incomplete_error, done;
  logic [5:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_stream_parser dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_last(in_last), .sync_found(sync_found),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .crc_error(crc_error), .fmt_error(fmt_error),
    .incomplete_error(incomplete_error), .done(done)
  );

  // kinds: 0 literal word, 1 upper CRC half, 2 lower CRC half
  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] word;
    logic        last;
    logic        stb;
    logic [5:0]  addr;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 16'hFFFF, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'hAA99, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h5566, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h30A2, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h1234, 1'b0, 1'b1, 6'd5},
    '{2'd0, 16'hBEEF, 1'b0, 1'b1, 6'd5},
    '{2'd0, 16'h2000, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h2861, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h4002, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h0A0A, 1'b0, 1'b1, 6'd3},
    '{2'd0, 16'h0B0B, 1'b0, 1'b1, 6'd3},
    '{2'd0, 16'h3002, 1'b0, 1'b0, 6'd0},
    '{2'd1, 16'h0000, 1'b0, 1'b0, 6'd0},
    '{2'd2, 16'h0000, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h37E1, 1'b0, 1'b0, 6'd0},
    '{2'd0, 16'h55AA, 1'b0, 1'b1, 6'd63},
    '{2'd0, 16'h3002, 1'b0, 1'b0, 6'd0}
  };

  function automatic logic [31:0] model_crc(input logic [31:0] s,
                                            input logic [5:0] a,
                                            input logic [15:0] d);
    logic [21:0] b;
    logic [31:0] r;
    b = {a, d};
    r = s;
    for (int k = 21; k >= 0; k--) begin
      if (r[31] ^ b[k]) r = (r << 1) ^ 32'h04C11DB7;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic l);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    in_last  = l;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_sync();
    send(16'hAA99, 1'b0);
    send(16'h5566, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] mcrc;
    do_reset();
    #1;
    // reset state
    chk(in_ready && !sync_found && !wr_strobe && !done && !incomplete_error
        && !crc_error && !fmt_error, "R8 reset state",
        {in_ready, sync_found, wr_strobe, done, incomplete_error, crc_error, fmt_error}, 7'b1000000);

    // table walk: valid image whose closing CRC word is also the last word
    mcrc = '0;
    for (int i = 0; i < NV + 2; i++) begin
      logic [15:0] w;
      logic        l, es;
      logic [5:0]  ea;
      if (i < NV) begin
        w = TBL[i].word; l = TBL[i].last; es = TBL[i].stb; ea = TBL[i].addr;
        if (TBL[i].kind == 2'd1) w = mcrc[31:16];
        if (TBL[i].kind == 2'd2) w = mcrc[15:0];
      end else begin
        es = 1'b0; ea = '0; l = (i == NV + 1);
        w = (i == NV) ? mcrc[31:16] : mcrc[15:0];
      end
      send(w, l);
      chk(wr_strobe == es, "R2 strobe per payload", wr_strobe, es);
      if (es) begin
        chk(wr_addr == ea && wr_data == w, "R2 address and data",
            {wr_addr, wr_data}, {ea, w});
        mcrc = model_crc(mcrc, ea, w);
      end
      if (i < NV && TBL[i].kind == 2'd2) mcrc = '0;
      if (i == 1) chk(!sync_found, "R1 not yet locked", sync_found, 0);
      if (i == 2) chk(sync_found, "R1 lock after pattern", sync_found, 1);
      if (i == 13) chk(!crc_error, "R5 running CRC matched", crc_error, 0);
      if (i == 7) chk(!wr_strobe, "R3 read header takes no payload", wr_strobe, 0);
    end
    chk(done && !crc_error && !incomplete_error, "R8 done with last CRC word",
        {done, crc_error, incomplete_error}, 3'b100);
    chk(!in_ready, "R8 ready low after end", in_ready, 0);
    chk(!fmt_error, "R7 no format error", fmt_error, 0);
    send(16'h30A2, 1'b0);
    send(16'h7777, 1'b0);
    chk(!wr_strobe && done, "R8 words ignored after end", {wr_strobe, done}, 2'b01);

    // CRC mismatch ends stream
    do_reset();
    send_sync();
    send(16'h3081, 1'b0);
    chk(!wr_strobe, "R2 header no strobe", wr_strobe, 0);
    send(16'hC0DE, 1'b0);
    chk(wr_strobe && wr_addr == 6'd4, "R2 write addr 4", {wr_strobe, wr_addr}, {1'b1, 6'd4});
    mcrc = model_crc(32'h0, 6'd4, 16'hC0DE);
    send(16'h3002, 1'b0);
    send(mcrc[31:16], 1'b0);
    chk(!wr_strobe && !crc_error, "R4 upper half no strobe", {wr_strobe, crc_error}, 0);
    send(mcrc[15:0] ^ 16'h0001, 1'b1);
    chk(crc_error && !done && !incomplete_error, "R9 mismatch blocks done",
        {crc_error, done, incomplete_error}, 3'b100);
    chk(!wr_strobe, "R4 CRC word not strobed", wr_strobe, 0);

    // truncated mid-packet; last word also a payload word
    do_reset();
    send_sync();
    send(16'h3082, 1'b0);
    send(16'h1111, 1'b1);
    chk(wr_strobe && incomplete_error && !done, "R8 truncated image",
        {wr_strobe, incomplete_error, done}, 3'b110);
    send(16'h2222, 1'b0);
    chk(!wr_strobe, "R8 back-pressure after end", wr_strobe, 0);

    // end before sync
    do_reset();
    send(16'h1234, 1'b1);
    chk(incomplete_error && !done && !sync_found, "R8 end before sync",
        {incomplete_error, done, sync_found}, 3'b100);

    // broken pair, then pair separated by idle cycles, plus format error
    do_reset();
    send(16'hAA99, 1'b0);
    send(16'hFFFF, 1'b0);
    send(16'h5566, 1'b0);
    chk(!sync_found, "R1 broken pair", sync_found, 0);
    send(16'h3081, 1'b0);
    send(16'h9999, 1'b0);
    chk(!wr_strobe, "R1 no decode before sync", wr_strobe, 0);
    send(16'hAA99, 1'b0);
    @(negedge clk);
    in_word = 16'h5566;
    repeat (4) @(negedge clk);
    chk(!sync_found, "R10 idle cycles consume nothing", sync_found, 0);
    send(16'h5566, 1'b0);
    chk(sync_found, "R10 pair across gap", sync_found, 1);
    send(16'hE123, 1'b0);
    chk(fmt_error, "R7 unknown kind flagged", fmt_error, 1);
    send(16'h3041, 1'b0);
    send(16'h4444, 1'b0);
    chk(wr_strobe && wr_addr == 6'd2 && wr_data == 16'h4444, "R7 next word is header",
        {wr_strobe, wr_addr, wr_data}, {1'b1, 6'd2, 16'h4444});
    // type-2 header continuing a CRC register address
    mcrc = model_crc(32'h0, 6'd2, 16'h4444);
    send(16'h2800, 1'b0);
    send(16'h4002, 1'b0);
    send(mcrc[31:16], 1'b0);
    send(mcrc[15:0], 1'b1);
    chk(done && !crc_error, "R6 type-2 CRC payload", {done, crc_error}, 2'b10);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule